// File: doc/BRIEF.md
# Multi-Mode PWM Timer Channel

This block is a free-running timer counter with a single compare channel. It produces a reference PWM waveform. In edge-aligned operation it counts up from zero to a reload limit, or down from that limit to zero. The direction comes from an input. In center-aligned operation it sweeps up and then down in a triangle. The block owns the direction itself in that case, and a configurable rule decides on which slope a compare match is flagged.

The limit and compare inputs pass through shadow registers. New values therefore take effect only at the point where a period restarts. While the counter is disabled, the shadows follow the inputs directly, so a configuration written with the enable low applies at once. A two-bit force control overrides the waveform with a fixed level. The counter keeps running while the override is on.

Top module: `pwm_timer_chan`

## Requirements
- R1: While reset is low, `count` is 0, `dirOut` is 0 and `matchFlag` is 0. With `forceCtl`=00, `pwmRef` is 0 during reset.
- R2: With `alignMode`=00 and `dirSel`=0, one cycle after the direction is latched, `dirOut` is 0 and `count` steps by +1 on each enabled cycle. From the reload limit A it wraps to 0, so starting from 0 the count at enabled cycle k is k mod (A+1).
- R3: With `alignMode`=00 and `dirSel`=1, `dirOut` is 1. On each enabled cycle `count` steps down by 1, and from 0 it reloads to A. Starting from 0 the count is (A+1 − k mod (A+1)) mod (A+1).
- R4: In edge up-counting, `pwmRef` is 1 exactly while `count` < C, where C is the compare value. With C = 0 it is always 0.
- R5: In edge down-counting, `pwmRef` is 1 exactly while `count` ≤ C. It is therefore 1 at least at count 0, and a zero duty cycle never occurs.
- R6: Whenever C > A, `pwmRef` stays at 1 in every counting mode.
- R7: With `alignMode` nonzero and A > 0, `count` runs 0,1,…,A,A−1,…,1 and repeats with period 2A. Each end value lasts one cycle. `dirOut` is 1 during the descending phase, from count A down to count 1, and 0 otherwise. `dirSel` has no effect in this mode.
- R8: In center-aligned mode, `pwmRef` is 1 exactly while `count` < C, for all three nonzero `alignMode` values alike.
- R9: In edge-aligned mode, `matchFlag` is 1 in exactly those enabled cycles in which `count` equals C.
- R10: In center-aligned mode, `matchFlag` is 1 when enabled and `count` equals C, subject to the slope:
  - `alignMode`=01 flags only while `dirOut`=1.
  - `alignMode`=10 flags only while `dirOut`=0.
  - `alignMode`=11 flags on both slopes.
- R11: `forceCtl`=10 holds `pwmRef` at 1 and `forceCtl`=01 holds it at 0. With 00 or 11 the waveform is normal. The counter keeps counting while forced.
- R12: While enabled, new limit and compare inputs take effect only at a period restart. That is the edge-up wrap to 0, the edge-down reload, or the center-aligned arrival at 0.
- R13: With `enable` low, `count` holds its value and `matchFlag` is 0. Counting resumes from the held value when `enable` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Counter run enable |
| dirSel | input | 1 | Edge-mode direction: 0 up, 1 down |
| alignMode | input | 2 | 00 edge-aligned; 01/10/11 center-aligned with flag slope rule |
| reloadVal | input | CNT_W | Reload limit A |
| compareVal | input | CNT_W | Compare value C |
| forceCtl | input | 2 | 01 force low, 10 force high, else normal |
| pwmRef | output | 1 | Reference PWM output |
| count | output | CNT_W | Current counter value |
| dirOut | output | 1 | Current counting direction (1 = down) |
| matchFlag | output | 1 | Compare-match indication |

## Verification
The step assertions in center-aligned mode assume the counter entered that mode from reset or from a period boundary. Under that assumption a descending nonzero count always belongs to a well-formed triangle. The bench therefore resets the block before every configuration and switches `alignMode` only while reset is held. The flag-slope checks assume the configuration inputs stay put through a run. Limits and compare values change only during reset, and once in the dedicated shadow-timing test.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  // Alignment selector codes; any nonzero code is center-aligned.
  localparam logic [1:0] ALIGN_EDGE      = 2'b00;
  localparam logic [1:0] ALIGN_FLAG_DOWN = 2'b01;
  localparam logic [1:0] ALIGN_FLAG_UP   = 2'b10;
  localparam logic [1:0] ALIGN_FLAG_BOTH = 2'b11;

  // Output override codes.
  localparam logic [1:0] FORCE_LOW  = 2'b01;
  localparam logic [1:0] FORCE_HIGH = 2'b10;

  // Strobes from control to datapath, one step decision per cycle.
  typedef struct packed {
    logic incr;
    logic decr;
    logic clearZero;
    logic loadTop;
    logic loadShadow;
    logic flagQual;
    logic useDownRule;
  } stepCtl_t;

endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dirSel,
  input  logic [1:0]       alignMode,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] arrSh,
  output stepCtl_t         ctl,
  output logic             dirQ
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic centerMode;
  logic dirNext;

  assign centerMode = |alignMode;

  always_comb begin
    ctl     = '0;
    dirNext = dirQ;
    if (!enable) begin
      ctl.loadShadow = 1'b1;
      if (!centerMode) dirNext = dirSel;
    end else if (!centerMode) begin
      dirNext = dirSel;
      if (!dirQ) begin
        if (count >= arrSh) begin
          ctl.clearZero  = 1'b1;
          ctl.loadShadow = 1'b1;
        end else begin
          ctl.incr = 1'b1;
        end
      end else begin
        if (count == '0) begin
          ctl.loadTop    = 1'b1;
          ctl.loadShadow = 1'b1;
        end else begin
          ctl.decr = 1'b1;
        end
      end
    end else begin
      if (arrSh == '0) begin
        ctl.clearZero  = 1'b1;
        ctl.loadShadow = 1'b1;
        dirNext        = 1'b0;
      end else if (!dirQ && count < arrSh) begin
        ctl.incr = 1'b1;
        if ((count + ONE) == arrSh) dirNext = 1'b1;
      end else if (count == '0) begin
        ctl.incr = 1'b1;
        dirNext  = 1'b0;
      end else if (count == ONE) begin
        ctl.decr       = 1'b1;
        ctl.loadShadow = 1'b1;
        dirNext        = 1'b0;
      end else begin
        ctl.decr = 1'b1;
        dirNext  = 1'b1;
      end
    end

    if (enable) begin
      case (alignMode)
        ALIGN_FLAG_DOWN: ctl.flagQual = dirQ;
        ALIGN_FLAG_UP:   ctl.flagQual = !dirQ;
        default:         ctl.flagQual = 1'b1;
      endcase
    end
    ctl.useDownRule = !centerMode && dirQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dirQ <= 1'b0;
    else       dirQ <= dirNext;
  end

  // R2
  edge_up_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !centerMode && !dirQ && count < arrSh) |=> (count - $past(count)) == ONE);

  // R7
  center_down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && centerMode && dirQ && count != '0) |=> ($past(count) - count) == ONE);

  // R7
  center_dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && centerMode && !dirQ && arrSh > ONE && (count + ONE) < arrSh) |=> !dirQ);

  // R13
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(count));

endmodule

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtl_t         ctl,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] compareVal,
  input  logic [1:0]       forceCtl,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] arrSh,
  output logic             pwmRef,
  output logic             matchFlag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] compSh;
  logic             rawRef;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arrSh  <= '0;
      compSh <= '0;
    end else if (ctl.loadShadow) begin
      arrSh  <= reloadVal;
      compSh <= compareVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              count <= '0;
    else if (ctl.clearZero) count <= '0;
    else if (ctl.loadTop)   count <= reloadVal;
    else if (ctl.incr)      count <= count + ONE;
    else if (ctl.decr)      count <= count - ONE;
  end

  always_comb begin
    if (compSh > arrSh)       rawRef = 1'b1;
    else if (ctl.useDownRule) rawRef = (count <= compSh);
    else                      rawRef = (count < compSh);
    case (forceCtl)
      FORCE_LOW:  pwmRef = 1'b0;
      FORCE_HIGH: pwmRef = 1'b1;
      default:    pwmRef = rawRef;
    endcase
  end

  assign matchFlag = ctl.flagQual && (count == compSh);

  // R11
  force_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceCtl == FORCE_HIGH) |-> pwmRef);

  // R11
  force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (forceCtl == FORCE_LOW) |-> !pwmRef);

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dirSel,
  input  logic [1:0]       alignMode,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] compareVal,
  input  logic [1:0]       forceCtl,
  output logic             pwmRef,
  output logic [CNT_W-1:0] count,
  output logic             dirOut,
  output logic             matchFlag
);

  stepCtl_t         stepCtl;
  logic [CNT_W-1:0] arrSh;

  pwm_chan_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .dirSel    (dirSel),
    .alignMode (alignMode),
    .count     (count),
    .arrSh     (arrSh),
    .ctl       (stepCtl),
    .dirQ      (dirOut)
  );

  pwm_chan_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (stepCtl),
    .reloadVal  (reloadVal),
    .compareVal (compareVal),
    .forceCtl   (forceCtl),
    .count      (count),
    .arrSh      (arrSh),
    .pwmRef     (pwmRef),
    .matchFlag  (matchFlag)
  );

  // R10
  flag_down_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && alignMode == ALIGN_FLAG_DOWN) |-> dirOut);

  // R10
  flag_up_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag && alignMode == ALIGN_FLAG_UP) |-> !dirOut);

  // R13
  flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !matchFlag);

endmodule

// File: tb/pwm_timer_chan_tb.sv
`timescale 1ns/1ps
module pwm_timer_chan_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         dirSel = 1'b0;
  logic [1:0]   alignMode = 2'b00;
  logic [W-1:0] reloadVal = '0;
  logic [W-1:0] compareVal = '0;
  logic [1:0]   forceCtl = 2'b00;
  logic         pwmRef;
  logic [W-1:0] count;
  logic         dirOut;
  logic         matchFlag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_timer_chan #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .dirSel(dirSel),
    .alignMode(alignMode), .reloadVal(reloadVal), .compareVal(compareVal),
    .forceCtl(forceCtl), .pwmRef(pwmRef), .count(count), .dirOut(dirOut),
    .matchFlag(matchFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int modelCount(int md, int dirS, int a, int k);
    int p;
    if (md == 0) begin
      if (dirS == 0) return k % (a + 1);
      return (a + 1 - (k % (a + 1))) % (a + 1);
    end
    p = k % (2 * a);
    return (p <= a) ? p : 2 * a - p;
  endfunction

  function automatic int modelDir(int md, int dirS, int a, int k);
    if (md == 0) return dirS;
    return ((k % (2 * a)) >= a) ? 1 : 0;
  endfunction

  function automatic int modelPwm(int md, int dirS, int a, int c, int cnt);
    if (c > a) return 1;
    if (md == 0 && dirS == 1) return (cnt <= c) ? 1 : 0;
    return (cnt < c) ? 1 : 0;
  endfunction

  function automatic int modelFlag(int md, int dir, int c, int cnt);
    if (cnt != c) return 0;
    if (md == 1) return dir;
    if (md == 2) return 1 - dir;
    return 1;
  endfunction

  // Reset, apply a configuration, then start counting at a falling edge.
  task automatic setup(input int md, input int dirS, input int a, input int c);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; forceCtl = 2'b00;
    alignMode = 2'(md); dirSel = dirS[0];
    reloadVal = W'(a); compareVal = W'(c);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    #1;
  endtask

  task automatic sweepOne(input int md, input int dirS, input int a, input int c);
    int n;
    int ec;
    int ed;
    string rc;
    string rp;
    string rf;
    setup(md, dirS, a, c);
    n = (md == 0) ? 2 * (a + 1) + 2 : 4 * a + 2;
    rc = (md != 0) ? "R7" : (dirS != 0 ? "R3" : "R2");
    rp = (c > a) ? "R6" : (md != 0 ? "R8" : (dirS != 0 ? "R5" : "R4"));
    rf = (md != 0) ? "R10" : "R9";
    for (int k = 0; k < n; k++) begin
      ec = modelCount(md, dirS, a, k);
      ed = modelDir(md, dirS, a, k);
      chk({rc, " count"}, int'(count), ec);
      chk({rc, " dir"}, int'(dirOut), ed);
      chk({rp, " pwm"}, int'(pwmRef), modelPwm(md, dirS, a, c, ec));
      chk({rf, " flag"}, int'(matchFlag), modelFlag(md, ed, c, ec));
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(dirOut), 0);
    chk("R1 flag", int'(matchFlag), 0);
    chk("R1 pwm", int'(pwmRef), 0);

    // Exhaustive sweep over small limits and compare values
    for (int m = 0; m < 5; m++) begin
      int md;
      int dirS;
      md   = (m < 2) ? 0 : m - 1;
      dirS = (m < 2) ? m : (m & 1);
      for (int a = (md == 0 ? 0 : 1); a <= 5; a++)
        for (int c = 0; c <= a + 2; c++)
          sweepOne(md, dirS, a, c);
    end

    // R11 force high over a zero-duty setting, counter keeps running
    setup(0, 0, 5, 0);
    forceCtl = 2'b10;
    #1;
    for (int k = 0; k < 8; k++) begin
      chk("R11 pwm forced high", int'(pwmRef), 1);
      chk("R11 count runs", int'(count), k % 6);
      @(negedge clk);
      #1;
    end
    // R11 force low over a saturated-high setting
    setup(2, 0, 3, 7);
    forceCtl = 2'b01;
    #1;
    for (int k = 0; k < 8; k++) begin
      chk("R11 pwm forced low", int'(pwmRef), 0);
      chk("R11 count runs", int'(count), modelCount(1, 0, 3, k));
      @(negedge clk);
      #1;
    end
    forceCtl = 2'b11;
    #1;
    chk("R11 code 11 normal", int'(pwmRef), 1);

    // R12 shadowed limit and compare take effect only at the wrap
    setup(0, 0, 4, 2);
    chk("R12 count", int'(count), 0);
    @(negedge clk);
    compareVal = W'(4); reloadVal = W'(6);
    #1;
    for (int k = 1; k <= 12; k++) begin
      int ec;
      if (k < 5) begin
        ec = k;
        chk("R12 old count", int'(count), ec);
        chk("R12 old pwm", int'(pwmRef), (ec < 2) ? 1 : 0);
      end else begin
        ec = (k - 5) % 7;
        chk("R12 new count", int'(count), ec);
        chk("R12 new pwm", int'(pwmRef), (ec < 4) ? 1 : 0);
      end
      @(negedge clk);
      #1;
    end

    // R13 freeze and resume
    setup(0, 0, 5, 3);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    #1;
    for (int k = 0; k < 3; k++) begin
      chk("R13 count held", int'(count), 3);
      chk("R13 flag low", int'(matchFlag), 0);
      @(negedge clk);
      #1;
    end
    enable = 1'b1;
    #1;
    chk("R13 flag on resume", int'(matchFlag), 1);
    @(negedge clk);
    #1;
    chk("R13 count resumes", int'(count), 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule